// File: doc/BRIEF.md
# Calibrated seconds prescaler

This block turns a 32768 Hz oscillator enable into a one-clock seconds strobe, and trims the rate with a signed correction held in a 16-bit calibration word. The oscillator arrives as a single-cycle enable in the system clock domain. A divide counter counts those enables, and every completed count produces one `sec_tick`.

The correction is an 8-bit two's-complement step count. Bit 15 of the word picks the step size. In fine mode a step is one oscillator cycle per 2^20 cycles, about 954 ppb, so the correction interval is 32 seconds. In coarse mode a step is one cycle per 2^18 cycles, about 3815 ppb, so the interval is 8 seconds. The whole correction for an interval is applied in the first second of that interval. A positive count removes that many oscillator cycles from that second, and a negative count adds them. The other seconds of the interval keep the nominal length.

Software writes the word through a simple write strobe and can read it back at any time. A new word is taken into use only when the current second ends. Bits 14..8 of the word are a guard field whose value depends on the sign. A word whose guard field does not match is refused.

Top module: `sec_prescaler`

## Requirements
- R1: After reset the calibration word reads 0x2000 (only bit 13 set: fine mode, zero correction) and `sec_tick` is low.
- R2: With zero correction every second lasts exactly 2^DIV_LOG2 oscillator enables (32768 by default).
- R3: `sec_tick` is high for exactly one clock, in the cycle right after the enable that completes a second. Clock cycles without `osc_en` do not advance the divider.
- R4: A positive correction c makes the first second of each interval last 2^DIV_LOG2 - c enables.
- R5: A negative correction c makes the first second of each interval last 2^DIV_LOG2 + |c| enables. All other seconds last 2^DIV_LOG2.
- R6: Bit 15 selects the interval. Clear means fine mode with 2^FINE_SHIFT seconds (default 32). Set means coarse mode with 2^COARSE_SHIFT seconds (default 8). Seconds are numbered from reset, and second 0 is the first second of an interval.
- R7: A write is accepted only when bits 14..8 equal {0, ~S, S, S, S, S, S}, where S is bit 7 (so bit 14 = 0, bit 13 = ~S, bits 12..8 = S). Any other write leaves the stored word unchanged.
- R8: `cal_rdata` always shows the stored word, and an accepted write becomes visible one clock after its strobe.
- R9: A word written during a second does not change the length of that second. It applies from the second that starts at the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| osc_en | input | 1 | One-clock enable per oscillator cycle |
| cal_we | input | 1 | Write strobe for the calibration word |
| cal_wdata | input | 16 | Calibration word to write |
| cal_rdata | output | 16 | Stored calibration word |
| sec_tick | output | 1 | One-clock strobe at the end of every second |

## Verification
The divider is driven both with an enable on every clock and with sparse random enables. This separates counting enables from counting clocks. Directed words cover zero, +100 fine, the extremes -128 and +127 in coarse mode, and -1 fine. Each second's enable count is compared with a model that knows which second opens an interval, so an error in the correction sign, the step size or the interval length appears on a different second. Words written partway through a second, random words with some guard fields corrupted, and the readback after every write show whether the word is taken at the boundary and whether bad words are refused.

// File: rtl/sec_prescaler_pkg.sv
package sec_prescaler_pkg;

  localparam int CAL_W = 16;

  // calibration word layout: mode | sign guard | signed step count
  typedef struct packed {
    logic       coarse;
    logic [6:0] guard;
    logic [7:0] steps;
  } cal_word_t;

  // bit 13 only: fine mode, no correction
  localparam logic [CAL_W-1:0] CAL_RESET = 16'h2000;

  function automatic logic guard_ok(input cal_word_t w);
    return w.guard == {1'b0, ~w.steps[7], {5{w.steps[7]}}};
  endfunction

endpackage

// File: rtl/cal_word_reg.sv
module cal_word_reg
  import sec_prescaler_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CAL_W-1:0] wdata,
  output cal_word_t        word
);

  cal_word_t word_q, word_d;
  cal_word_t wr_word;

  assign wr_word = cal_word_t'(wdata);

  always_comb begin
    word_d = word_q;
    if (we && guard_ok(wr_word)) word_d = wr_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= cal_word_t'(CAL_RESET);
    else        word_q <= word_d;
  end

  assign word = word_q;

  // R7: a malformed write leaves the word alone
  a_r7_bad_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !guard_ok(wr_word)) |=> $stable(word_q));

  // R7: the stored word always carries a valid guard field
  a_r7_stored_guard_valid: assert property (@(posedge clk) disable iff (!rst_n)
    guard_ok(word_q));

endmodule

// File: rtl/sec_scheduler.sv
module sec_scheduler
  import sec_prescaler_pkg::*;
#(
  parameter int DIV_LOG2     = 15,
  parameter int FINE_SHIFT   = 5,
  parameter int COARSE_SHIFT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary,
  input  cal_word_t         sw_word,
  output logic [DIV_LOG2:0] period
);

  localparam int PER_W = DIV_LOG2 + 1;
  localparam logic [PER_W-1:0] NOMINAL = PER_W'(1) << DIV_LOG2;
  localparam logic [FINE_SHIFT-1:0] COARSE_MASK = FINE_SHIFT'((1 << COARSE_SHIFT) - 1);

  cal_word_t             act_q, act_d;
  logic [FINE_SHIFT-1:0] sec_q, sec_d;
  logic                  corr_sec;
  logic [PER_W-1:0]      steps_ext;

  // first second of the interval selected by the active mode
  assign corr_sec  = act_q.coarse ? ((sec_q & COARSE_MASK) == '0) : (sec_q == '0);
  assign steps_ext = {{(PER_W-8){act_q.steps[7]}}, act_q.steps};
  assign period    = corr_sec ? (NOMINAL - steps_ext) : NOMINAL;

  always_comb begin
    act_d = act_q;
    sec_d = sec_q;
    if (boundary) begin
      act_d = sw_word;
      sec_d = sec_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= cal_word_t'(CAL_RESET);
      sec_q <= '0;
    end else begin
      act_q <= act_d;
      sec_q <= sec_d;
    end
  end

  // R9: the word in use changes only at a second boundary
  a_r9_active_held: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(act_q));

  // R6: the seconds index moves only at a boundary
  a_r6_index_held: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(sec_q));

endmodule

// File: rtl/osc_divider.sv
module osc_divider #(
  parameter int DIV_LOG2 = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_en,
  input  logic [DIV_LOG2:0] period,
  output logic              boundary,
  output logic              tick
);

  localparam int PER_W = DIV_LOG2 + 1;

  logic [PER_W-1:0] cnt_q, cnt_d;
  logic             tick_q;

  assign boundary = osc_en && (cnt_q == period - PER_W'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (osc_en) cnt_d = boundary ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= boundary;
    end
  end

  assign tick = tick_q;

  // R3: single-cycle strobe
  a_r3_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |=> !tick_q);

  // R3: a strobe always follows an oscillator enable
  a_r3_tick_after_osc: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |-> $past(osc_en));

  // R2: the count never reaches the period in force
  a_r2_cnt_below_period: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < period);

  // R3: idle cycles do not move the count
  a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |=> $stable(cnt_q));

endmodule

// File: rtl/sec_prescaler.sv
module sec_prescaler
  import sec_prescaler_pkg::*;
#(
  parameter int DIV_LOG2     = 15,
  parameter int FINE_SHIFT   = 5,
  parameter int COARSE_SHIFT = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        osc_en,
  input  logic        cal_we,
  input  logic [15:0] cal_wdata,
  output logic [15:0] cal_rdata,
  output logic        sec_tick
);

  logic [1:0]        rst_pipe;
  logic              rst_n_sync;
  cal_word_t         word;
  logic              boundary;
  logic [DIV_LOG2:0] period;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe[1];

  cal_word_reg u_cal (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .we    (cal_we),
    .wdata (cal_wdata),
    .word  (word)
  );

  sec_scheduler #(
    .DIV_LOG2     (DIV_LOG2),
    .FINE_SHIFT   (FINE_SHIFT),
    .COARSE_SHIFT (COARSE_SHIFT)
  ) u_sched (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .boundary (boundary),
    .sw_word  (word),
    .period   (period)
  );

  osc_divider #(
    .DIV_LOG2 (DIV_LOG2)
  ) u_div (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .osc_en   (osc_en),
    .period   (period),
    .boundary (boundary),
    .tick     (sec_tick)
  );

  assign cal_rdata = word;

endmodule

// File: tb/sec_prescaler_test.sv
module sec_prescaler_test;

  localparam int N = 8;
  localparam int F = 3;
  localparam int C = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        osc_en = 1'b0;
  logic        cal_we = 1'b0;
  logic [15:0] cal_wdata = '0;
  logic [15:0] cal_rdata;
  logic        sec_tick;

  always #10 clk = ~clk;

  sec_prescaler #(.DIV_LOG2(N), .FINE_SHIFT(F), .COARSE_SHIFT(C)) uut (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .cal_we(cal_we),
    .cal_wdata(cal_wdata), .cal_rdata(cal_rdata), .sec_tick(sec_tick)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  function automatic bit word_valid(input logic [15:0] w);
    return (w[14] == 1'b0) && (w[13] == ~w[7]) && (w[12:8] == {5{w[7]}});
  endfunction

  function automatic logic [15:0] make_word(input bit coarse, input int steps);
    logic [7:0] s8;
    s8 = 8'(steps);
    return {coarse, 1'b0, ~s8[7], {5{s8[7]}}, s8};
  endfunction

  function automatic int exp_len(input int k, input logic [15:0] w);
    int sh;
    int st;
    sh = w[15] ? C : F;
    st = int'($signed(w[7:0]));
    return ((k % (1 << sh)) == 0) ? (1 << N) - st : (1 << N);
  endfunction

  // reference model state
  logic [15:0] pend = 16'h2000;
  logic [15:0] active = 16'h2000;
  logic [15:0] staged_w = '0;
  logic [15:0] last_good = 16'h2000;
  bit  staged = 0;
  bit  mon_on = 0;
  bit  prev_tick = 0;
  bit  prev_osc = 0;
  bit  cur_changed = 0;
  int  k = 0;
  int  cnt = 0;
  int  tick_total = 0;
  int  density = 100;
  bit  run_osc = 0;

  // monitor: away from the active edge
  always @(negedge clk) begin
    if (mon_on) begin
      if (sec_tick) begin
        string tag;
        int st;
        int e;
        st = int'($signed(active[7:0]));
        tag = cur_changed ? "R9" : (st == 0 ? "R2" : (st > 0 ? "R4/R6" : "R5/R6"));
        check(prev_osc, "R3 tick after enable", int'(prev_osc), 1);
        check(!prev_tick, "R3 single-cycle tick", int'(prev_tick), 0);
        e = exp_len(k, active);
        check(cnt == e, tag, cnt, e);
        k++;
        cur_changed = (pend != active);
        active = pend;
        cnt = 0;
        tick_total++;
      end
      if (staged) pend = staged_w;
      staged = cal_we && word_valid(cal_wdata);
      staged_w = cal_wdata;
      if (osc_en) cnt++;
      prev_tick = sec_tick;
      prev_osc = osc_en;
    end
  end

  // oscillator enable source
  always @(posedge clk) begin
    #1;
    osc_en = run_osc && (($urandom % 100) < density);
  end

  task automatic wait_ticks(input int n);
    int target;
    target = tick_total + n;
    while (tick_total < target) @(negedge clk);
  endtask

  task automatic write_cal(input logic [15:0] w, input string req);
    @(posedge clk); #1;
    cal_we = 1'b1;
    cal_wdata = w;
    @(posedge clk); #1;
    cal_we = 1'b0;
    if (word_valid(w)) last_good = w;
    @(negedge clk);
    check(cal_rdata == last_good, req, int'(cal_rdata), int'(last_good));
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(sec_tick == 1'b0, "R1 tick in reset", int'(sec_tick), 0);
    check(cal_rdata == 16'h2000, "R1 word in reset", int'(cal_rdata), 16'h2000);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(sec_tick == 1'b0, "R1 tick after reset", int'(sec_tick), 0);
    check(cal_rdata == 16'h2000, "R1 word after reset", int'(cal_rdata), 16'h2000);
    mon_on = 1;
    run_osc = 1;

    // R2: zero correction, dense and sparse enables (R3)
    density = 100;
    wait_ticks(3);
    density = 60;
    wait_ticks(2);

    // R4: positive fine correction, written mid-second (R9)
    density = 100;
    repeat (40) @(posedge clk);
    write_cal(make_word(0, 100), "R8 readback +100 fine");
    wait_ticks(10);

    // R5/R6: extreme negative, coarse
    density = 70;
    write_cal(make_word(1, -128), "R8 readback -128 coarse");
    wait_ticks(6);

    // R4/R6: extreme positive, coarse
    density = 100;
    write_cal(make_word(1, 127), "R8 readback +127 coarse");
    wait_ticks(5);

    // R7: guard field wrong, must be refused
    write_cal(16'h0005, "R7 bad guard ignored");
    write_cal(16'h2085, "R7 bad guard for negative ignored");
    wait_ticks(3);

    // R5: smallest negative step, fine
    write_cal(make_word(0, -1), "R8 readback -1 fine");
    wait_ticks(9);

    // random words, some corrupted
    for (int i = 0; i < 8; i++) begin
      logic [15:0] w;
      w = make_word(bit'($urandom % 2), int'($urandom % 256) - 128);
      if (($urandom % 4) == 0) w[14] = 1'b1;
      density = 30 + int'($urandom % 71);
      write_cal(w, word_valid(w) ? "R8 random readback" : "R7 random bad word");
      wait_ticks(1 + int'($urandom % 4));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule